// File: doc/BRIEF.md
# Counting Register Scoreboard

This block decides, one cycle at a time, whether an in-order issue stage may send an instruction on. For every architectural register, integer and floating-point alike, it keeps a small counter of the instructions already in flight that will write that register. An instruction asking to issue names up to three sources, up to two destinations and the pipeline length of the functional unit it targets. The grant comes back in the same cycle, and only when none of the sources is still waiting on a writer.

When a grant is given, each named destination's counter goes up. Its estimated result-ready cycle is set to the block's free-running cycle count plus the unit's latency. A retirement port names up to two destinations whose writes have finished, and each named counter goes down. For a memory operation, the retirement is presented when the memory response commits. Counters saturate instead of wrapping: an issue that would push a destination past the counter maximum is held back. A retirement against a counter that is already empty raises a one-cycle error flag. A side query port reads back any register's count and ready time.

Register indices are one bit wider than the per-file index. The top bit selects the file (0 integer, 1 floating point). Integer register 0 can be treated as hard-wired, so it is never tracked.

Top module: `reg_scoreboard`

## Requirements
- R1: `iss_grant` is high in a cycle only if `iss_valid` is high and every source slot whose valid bit is set names a register whose count is zero. A source slot with its valid bit clear is not looked at.
- R2: On a granted issue, each destination register's count rises by the number of valid destination slots naming it, visible on `qry_cnt` after the clock edge.
- R3: On a granted issue, each named destination's ready time becomes `cycle_now + iss_lat` as seen in the issue cycle, truncated to the time width. It is read on `qry_ready` after the edge.
- R4: Each valid retirement slot lowers the named register's count by one. An issue and a retirement naming the same register in one cycle leave its count unchanged.
- R5: Counts are 3 bits wide, with a maximum of 7. The grant is withheld when any destination's count plus the number of destination slots naming it would exceed 7. A count at 7 therefore stays at 7 until it is retired.
- R6: A retirement that would take a count below zero drives `err_o` high for exactly the following cycle and leaves that count at zero.
- R7: With the hard-wired zero option on (the default), index 0 is never counted and never blocks issue as a source or as a destination. A retirement naming it changes nothing and raises no error.
- R8: Index bit 5 selects the floating-point file. Floating-point register k (index 32+k) is tracked separately from integer register k, and floating-point register 0 (index 32) is counted normally.
- R9: After reset, every count and ready time is zero, `err_o` is low and `cycle_now` is zero.
- R10: With `iss_valid` low and no valid retirement slot, no count and no ready time changes, and `iss_grant` is low.
- R11: `cycle_now` rises by one on every clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An instruction requests issue this cycle |
| iss_src_vld | input | 3 | Valid bit for each source slot |
| iss_src | input | 3x6 | Source register indices (bit 5 selects the floating-point file) |
| iss_dst_vld | input | 2 | Valid bit for each destination slot |
| iss_dst | input | 2x6 | Destination register indices |
| iss_lat | input | 4 | Pipeline length of the target functional unit |
| iss_grant | output | 1 | Issue allowed this cycle |
| cmt_vld | input | 2 | Valid bit for each retirement slot |
| cmt_dst | input | 2x6 | Destination registers being retired |
| err_o | output | 1 | One-cycle pulse after a retirement against an empty count |
| qry_reg | input | 6 | Register index to read back |
| qry_cnt | output | 3 | Writer count of the queried register |
| qry_ready | output | 16 | Estimated ready cycle of the queried register |
| cycle_now | output | 16 | Free-running cycle count |

## Verification
The bench goes after the slots that share a register. These are an issue and a retirement on the same register in one cycle, where a design that applied only one of them would drift the count, and both destination slots naming one register near saturation. In that second case, a design that checked each slot alone would wrap 6 plus 2 to 0 and lose track of the writers. It probes each source slot separately, so a gate that ignored one slot grants a read of a pending register. It also checks that the retired-when-empty case pulses the flag once and pins the count at zero rather than wrapping to 7. A sweep of all 64 indices with different latencies exposes wrong file selection or a wrong ready-time sum. A long irregular run over a few crowded registers compares every count and ready time against an arithmetic model.

// File: rtl/sb_pkg.sv
// Shared constants for the counting register scoreboard.
// Assumes fixed slot counts on the issue and retirement interfaces.
package sb_pkg;
    localparam int unsigned SRC_SLOTS = 3;
    localparam int unsigned DST_SLOTS = 2;
    localparam int unsigned HIT_W     = $clog2(DST_SLOTS + 1);
endpackage

// File: rtl/sb_issue_gate.sv
// Issue gate: combinational decision whether the offered instruction may issue.
// Assumes the caller supplies the current writer count of every register.
module sb_issue_gate
    import sb_pkg::*;
#(
    parameter int NREG           = 64,
    parameter int REG_W          = 6,
    parameter int CNT_W          = 3,
    parameter bit HARDWIRED_ZERO = 1'b1
) (
    input  logic                              iss_valid,
    input  logic [SRC_SLOTS-1:0]              src_vld,
    input  logic [SRC_SLOTS-1:0][REG_W-1:0]   src,
    input  logic [DST_SLOTS-1:0]              dst_vld,
    input  logic [DST_SLOTS-1:0][REG_W-1:0]   dst,
    input  logic [NREG-1:0][CNT_W-1:0]        cnt,
    output logic                              grant
);
    localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

    logic           src_ok;
    logic           dst_ok;
    logic [CNT_W:0] need;

    // Sources must have no pending writer; destinations must have headroom.
    always_comb begin
        src_ok = 1'b1;
        dst_ok = 1'b1;
        need   = '0;
        for (int s = 0; s < SRC_SLOTS; s++) begin
            if (src_vld[s] && !(HARDWIRED_ZERO && src[s] == '0) && cnt[src[s]] != '0)
                src_ok = 1'b0;
        end
        for (int d = 0; d < DST_SLOTS; d++) begin
            if (dst_vld[d] && !(HARDWIRED_ZERO && dst[d] == '0)) begin
                need = {1'b0, cnt[dst[d]]};
                for (int e = 0; e < DST_SLOTS; e++) begin
                    if (dst_vld[e] && dst[e] == dst[d])
                        need = need + 1'b1;
                end
                if (need > CNT_MAX)
                    dst_ok = 1'b0;
            end
        end
        grant = iss_valid && src_ok && dst_ok;
    end
endmodule

// File: rtl/sb_reg_cell.sv
// One register's tracking state: writer count and estimated ready cycle.
// Assumes the increment never pushes the count past its maximum (the gate ensures it).
module sb_reg_cell #(
    parameter int CNT_W = 3,
    parameter int HIT_W = 2,
    parameter int TW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HIT_W-1:0] inc,
    input  logic [HIT_W-1:0] dec,
    input  logic [TW-1:0]    ready_in,
    output logic [CNT_W-1:0] cnt,
    output logic [TW-1:0]    ready,
    output logic             underflow
);
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] cnt_q;
    logic [TW-1:0]    ready_q;

    // Net effect of this cycle's issue and retirement on the count.
    always_comb begin
        sum       = {1'b0, cnt_q} + (CNT_W+1)'(inc);
        underflow = sum < (CNT_W+1)'(dec);
    end

    // Count update, clamped at zero when retirements exceed the writers.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (underflow)
            cnt_q <= '0;
        else
            cnt_q <= CNT_W'(sum - (CNT_W+1)'(dec));
    end

    // Ready time is recaptured whenever a new writer issues.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ready_q <= '0;
        else if (inc != '0)
            ready_q <= ready_in;
    end

    assign cnt   = cnt_q;
    assign ready = ready_q;
endmodule

// File: rtl/reg_scoreboard.sv
// Counting register scoreboard: per-register writer counts gate in-order issue,
// retirements release them, and each destination records an estimated ready cycle.
// Assumes REGS_PER_FILE is a power of two; index top bit selects the FP file.
module reg_scoreboard
    import sb_pkg::*;
#(
    parameter int REGS_PER_FILE  = 32,
    parameter int CNT_W          = 3,
    parameter int LAT_W          = 4,
    parameter int TW             = 16,
    parameter bit HARDWIRED_ZERO = 1'b1,
    localparam int REG_W         = $clog2(REGS_PER_FILE) + 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             iss_valid,
    input  logic [2:0]                       iss_src_vld,
    input  logic [2:0][REG_W-1:0]            iss_src,
    input  logic [1:0]                       iss_dst_vld,
    input  logic [1:0][REG_W-1:0]            iss_dst,
    input  logic [LAT_W-1:0]                 iss_lat,
    output logic                             iss_grant,
    input  logic [1:0]                       cmt_vld,
    input  logic [1:0][REG_W-1:0]            cmt_dst,
    output logic                             err_o,
    input  logic [REG_W-1:0]                 qry_reg,
    output logic [CNT_W-1:0]                 qry_cnt,
    output logic [TW-1:0]                    qry_ready,
    output logic [TW-1:0]                    cycle_now
);
    localparam int NREG = 2 * REGS_PER_FILE;

    logic [NREG-1:0][CNT_W-1:0] cnt_all;
    logic [NREG-1:0][TW-1:0]    rdy_all;
    logic [NREG-1:0]            uf_vec;
    logic [TW-1:0]              cyc_q;
    logic [TW-1:0]              ready_in;
    logic                       err_q;

    sb_issue_gate #(
        .NREG(NREG), .REG_W(REG_W), .CNT_W(CNT_W), .HARDWIRED_ZERO(HARDWIRED_ZERO)
    ) u_gate (
        .iss_valid (iss_valid),
        .src_vld   (iss_src_vld),
        .src       (iss_src),
        .dst_vld   (iss_dst_vld),
        .dst       (iss_dst),
        .cnt       (cnt_all),
        .grant     (iss_grant)
    );

    assign ready_in = cyc_q + TW'(iss_lat);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam bit TRACKED = !(HARDWIRED_ZERO && i == 0);
        logic [HIT_W-1:0] inc;
        logic [HIT_W-1:0] dec;

        // Count how many issue and retirement slots name this register.
        always_comb begin
            inc = '0;
            dec = '0;
            for (int d = 0; d < DST_SLOTS; d++) begin
                if (TRACKED && iss_grant && iss_dst_vld[d] && iss_dst[d] == REG_W'(i))
                    inc = inc + 1'b1;
                if (TRACKED && cmt_vld[d] && cmt_dst[d] == REG_W'(i))
                    dec = dec + 1'b1;
            end
        end

        sb_reg_cell #(.CNT_W(CNT_W), .HIT_W(HIT_W), .TW(TW)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc       (inc),
            .dec       (dec),
            .ready_in  (ready_in),
            .cnt       (cnt_all[i]),
            .ready     (rdy_all[i]),
            .underflow (uf_vec[i])
        );
    end

    // Free-running cycle count used as the time base for ready estimates.
    always_ff @(posedge clk) begin
        if (!rst_n) cyc_q <= '0;
        else        cyc_q <= cyc_q + 1'b1;
    end

    // Error pulse for one cycle after any retirement against an empty count.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= |uf_vec;
    end

    assign err_o     = err_q;
    assign cycle_now = cyc_q;
    assign qry_cnt   = cnt_all[qry_reg];
    assign qry_ready = rdy_all[qry_reg];
endmodule

// File: rtl/reg_scoreboard_chk.sv
// Property checker for reg_scoreboard, attached by bind below.
// Recomputes slot hits from the ports and relates them to the tracked counts.
module reg_scoreboard_chk #(
    parameter int NREG           = 64,
    parameter int REG_W          = 6,
    parameter int CNT_W          = 3,
    parameter int TW             = 16,
    parameter bit HARDWIRED_ZERO = 1'b1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        iss_grant,
    input logic [2:0]                  iss_src_vld,
    input logic [2:0][REG_W-1:0]       iss_src,
    input logic [1:0]                  iss_dst_vld,
    input logic [1:0][REG_W-1:0]       iss_dst,
    input logic [1:0]                  cmt_vld,
    input logic [1:0][REG_W-1:0]       cmt_dst,
    input logic                        err_o,
    input logic [TW-1:0]               cycle_now,
    input logic [NREG-1:0][CNT_W-1:0]  cnt_all
);
    logic [NREG-1:0][1:0] c_inc;
    logic [NREG-1:0][1:0] c_dec;
    logic                 src_clear;

    // Independent view of per-register activity and source readiness.
    always_comb begin
        src_clear = 1'b1;
        for (int s = 0; s < 3; s++)
            if (iss_src_vld[s] && !(HARDWIRED_ZERO && iss_src[s] == '0) && cnt_all[iss_src[s]] != '0)
                src_clear = 1'b0;
        for (int r = 0; r < NREG; r++) begin
            c_inc[r] = '0;
            c_dec[r] = '0;
            for (int d = 0; d < 2; d++) begin
                if (!(HARDWIRED_ZERO && r == 0) && iss_grant && iss_dst_vld[d] && iss_dst[d] == REG_W'(r))
                    c_inc[r] = c_inc[r] + 1'b1;
                if (!(HARDWIRED_ZERO && r == 0) && cmt_vld[d] && cmt_dst[d] == REG_W'(r))
                    c_dec[r] = c_dec[r] + 1'b1;
            end
        end
    end

    // R1
    grant_src_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_grant |-> src_clear);

    // R6
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(|cmt_vld));

    // R11
    cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cycle_now == $past(cycle_now) + 1'b1);

    if (HARDWIRED_ZERO) begin : g_zero
        // R7
        zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_all[0] == '0);
    end

    for (genvar i = 0; i < NREG; i++) begin : g_per_reg
        // R10
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (c_inc[i] == '0 && c_dec[i] == '0) |=> $stable(cnt_all[i]));
        // R2
        issue_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (c_inc[i] != '0 && c_dec[i] == '0) |=>
            {1'b0, cnt_all[i]} == {1'b0, $past(cnt_all[i])} + (CNT_W+1)'($past(c_inc[i])));
        // R5
        no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_all[i] == {CNT_W{1'b1}} && c_dec[i] == '0) |=> cnt_all[i] == {CNT_W{1'b1}});
    end
endmodule

bind reg_scoreboard reg_scoreboard_chk #(
    .NREG(2 * REGS_PER_FILE), .REG_W(REG_W), .CNT_W(CNT_W), .TW(TW),
    .HARDWIRED_ZERO(HARDWIRED_ZERO)
) u_chk (
    .clk(clk), .rst_n(rst_n), .iss_grant(iss_grant),
    .iss_src_vld(iss_src_vld), .iss_src(iss_src),
    .iss_dst_vld(iss_dst_vld), .iss_dst(iss_dst),
    .cmt_vld(cmt_vld), .cmt_dst(cmt_dst),
    .err_o(err_o), .cycle_now(cycle_now), .cnt_all(cnt_all)
);

// File: tb/reg_scoreboard_tb.sv
// Self-checking bench: directed corner cases, a full index sweep and a long
// irregular run, all compared against an arithmetic model of counts and times.
module reg_scoreboard_tb;
    localparam int REG_W = 6;
    localparam int NREG  = 64;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  iss_valid = 1'b0;
    logic [2:0]            iss_src_vld = '0;
    logic [2:0][REG_W-1:0] iss_src = '0;
    logic [1:0]            iss_dst_vld = '0;
    logic [1:0][REG_W-1:0] iss_dst = '0;
    logic [3:0]            iss_lat = '0;
    logic                  iss_grant;
    logic [1:0]            cmt_vld = '0;
    logic [1:0][REG_W-1:0] cmt_dst = '0;
    logic                  err_o;
    logic [REG_W-1:0]      qry_reg = '0;
    logic [2:0]            qry_cnt;
    logic [15:0]           qry_ready;
    logic [15:0]           cycle_now;

    int          n_chk = 0;
    int          n_fail = 0;
    int          m_cnt [NREG];
    int          m_rdy [NREG];
    int          m_now = 0;
    bit          m_err = 0;
    bit          last_grant = 0;

    reg_scoreboard u_dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid),
        .iss_src_vld(iss_src_vld), .iss_src(iss_src),
        .iss_dst_vld(iss_dst_vld), .iss_dst(iss_dst), .iss_lat(iss_lat),
        .iss_grant(iss_grant), .cmt_vld(cmt_vld), .cmt_dst(cmt_dst),
        .err_o(err_o), .qry_reg(qry_reg), .qry_cnt(qry_cnt),
        .qry_ready(qry_ready), .cycle_now(cycle_now)
    );

    // 50 MHz: 20-unit period with 1 ns units.
    always #10 clk = ~clk;

    // Model time base: one step per edge out of reset.
    always @(posedge clk) if (rst_n) m_now <= (m_now + 1) % 65536;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare every register's count and ready time through the query port.
    task automatic check_all(input string req);
        int bad_c = -1;
        int bad_r = -1;
        int ac = 0, ec = 0, ar = 0, er = 0;
        for (int r = 0; r < NREG; r++) begin
            qry_reg = REG_W'(r);
            #1;
            if (bad_c < 0 && int'(qry_cnt) != m_cnt[r]) begin bad_c = r; ac = qry_cnt; ec = m_cnt[r]; end
            if (bad_r < 0 && int'(qry_ready) != m_rdy[r]) begin bad_r = r; ar = qry_ready; er = m_rdy[r]; end
        end
        chk(bad_c < 0, {req, " count"}, ac, ec);
        chk(bad_r < 0, {req, " ready"}, ar, er);
        @(negedge clk);
    endtask

    // One cycle of stimulus, started at a falling edge; model updated at the edge.
    task automatic step(input bit v, input bit [2:0] sv, input int s0, input int s1, input int s2,
                        input bit [1:0] dv, input int d0, input int d1, input int lat,
                        input bit [1:0] cv, input int c0, input int c1, input string req);
        int  sa[3];
        int  da[2];
        int  ca[2];
        bit  g;
        int  nc[NREG];
        sa[0] = s0; sa[1] = s1; sa[2] = s2;
        da[0] = d0; da[1] = d1; ca[0] = c0; ca[1] = c1;
        iss_valid = v; iss_src_vld = sv; iss_dst_vld = dv; iss_lat = 4'(lat); cmt_vld = cv;
        for (int k = 0; k < 3; k++) iss_src[k] = REG_W'(sa[k]);
        for (int k = 0; k < 2; k++) begin iss_dst[k] = REG_W'(da[k]); cmt_dst[k] = REG_W'(ca[k]); end
        #1;
        g = v;
        for (int k = 0; k < 3; k++)
            if (sv[k] && sa[k] != 0 && m_cnt[sa[k]] != 0) g = 0;
        for (int k = 0; k < 2; k++)
            if (dv[k] && da[k] != 0)
                if (m_cnt[da[k]] + int'(dv[0] && da[0] == da[k]) + int'(dv[1] && da[1] == da[k]) > 7) g = 0;
        chk(iss_grant == g, {req, " grant"}, iss_grant, g);
        last_grant = iss_grant;
        m_err = 0;
        for (int r = 0; r < NREG; r++) begin
            int inc = 0;
            int dec = 0;
            nc[r] = m_cnt[r];
            if (r == 0) continue;
            for (int k = 0; k < 2; k++) begin
                if (g && dv[k] && da[k] == r) inc++;
                if (cv[k] && ca[k] == r) dec++;
            end
            if (m_cnt[r] + inc < dec) begin m_err = 1; nc[r] = 0; end
            else nc[r] = m_cnt[r] + inc - dec;
            if (inc > 0) m_rdy[r] = (m_now + lat) % 65536;
        end
        @(posedge clk);
        #1;
        m_cnt = nc;
        chk(err_o == m_err, "R6 error pulse", err_o, m_err);
        iss_valid = 0; iss_src_vld = '0; iss_dst_vld = '0; cmt_vld = '0;
        @(negedge clk);
        chk(int'(cycle_now) == m_now, "R11 cycle count", cycle_now, m_now);
    endtask

    task automatic idle(input string req);
        step(0, 3'b000, 0, 0, 0, 2'b00, 0, 0, 0, 2'b00, 0, 0, req);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int r = 0; r < NREG; r++) begin m_cnt[r] = 0; m_rdy[r] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: reset state
        chk(err_o == 1'b0, "R9 err after reset", err_o, 0);
        chk(cycle_now == 16'd0, "R9 cycle after reset", cycle_now, 0);
        chk(iss_grant == 1'b0, "R10 no grant when idle", iss_grant, 0);
        check_all("R9");

        // R7: register 0 as source and destination never blocks or counts
        step(1, 3'b001, 0, 0, 0, 2'b01, 0, 0, 5, 2'b00, 0, 0, "R7");
        chk(last_grant == 1'b1, "R7 zero reg grant", last_grant, 1);
        step(0, 3'b000, 0, 0, 0, 2'b00, 0, 0, 0, 2'b01, 0, 0, "R7 retire zero");
        check_all("R7");

        // R2/R3: issue writer of int r5 with latency 3
        step(1, 3'b000, 0, 0, 0, 2'b01, 5, 0, 3, 2'b00, 0, 0, "R2");
        check_all("R3");

        // R1: each source slot alone sees the pending writer
        for (int s = 0; s < 3; s++) begin
            step(1, 3'(1 << s), 5, 5, 5, 2'b00, 0, 0, 0, 2'b00, 0, 0, "R1");
            chk(last_grant == 1'b0, "R1 slot blocked", last_grant, 0);
        end
        step(1, 3'b110, 5, 7, 8, 2'b00, 0, 0, 0, 2'b00, 0, 0, "R1 invalid slot");
        chk(last_grant == 1'b1, "R1 invalid slot ignored", last_grant, 1);

        // R8: floating-point file is distinct
        step(1, 3'b000, 0, 0, 0, 2'b01, 37, 0, 9, 2'b00, 0, 0, "R8");
        step(1, 3'b001, 37, 0, 0, 2'b00, 0, 0, 0, 2'b00, 0, 0, "R8 fp5 blocked");
        chk(last_grant == 1'b0, "R8 fp5 blocked", last_grant, 0);
        step(1, 3'b001, 6, 0, 0, 2'b01, 32, 0, 2, 2'b00, 0, 0, "R8 fp0 counted");
        chk(last_grant == 1'b1, "R8 int6 free", last_grant, 1);
        check_all("R8");

        // R4: issue and retire the same register in one cycle
        step(1, 3'b000, 0, 0, 0, 2'b01, 5, 0, 7, 2'b01, 5, 0, "R4");
        check_all("R4 same cycle");
        step(0, 3'b000, 0, 0, 0, 2'b00, 0, 0, 0, 2'b11, 5, 37, "R4 retire");
        step(0, 3'b000, 0, 0, 0, 2'b00, 0, 0, 0, 2'b01, 32, 0, "R4 retire");
        check_all("R4");

        // R5: saturation at 7, and two slots on one register near the top
        for (int k = 0; k < 7; k++)
            step(1, 3'b000, 0, 0, 0, 2'b01, 10, 0, 1, 2'b00, 0, 0, "R5 fill");
        step(1, 3'b000, 0, 0, 0, 2'b01, 10, 0, 1, 2'b00, 0, 0, "R5");
        chk(last_grant == 1'b0, "R5 full blocked", last_grant, 0);
        step(0, 3'b000, 0, 0, 0, 2'b00, 0, 0, 0, 2'b01, 10, 0, "R5 retire one");
        step(1, 3'b000, 0, 0, 0, 2'b11, 10, 10, 4, 2'b00, 0, 0, "R5 pair");
        chk(last_grant == 1'b0, "R5 pair overflow blocked", last_grant, 0);
        step(1, 3'b000, 0, 0, 0, 2'b01, 10, 0, 4, 2'b00, 0, 0, "R5 single");
        check_all("R5");
        for (int k = 0; k < 3; k++)
            step(0, 3'b000, 0, 0, 0, 2'b00, 0, 0, 0, 2'b11, 10, 10, "R4 double retire");
        step(0, 3'b000, 0, 0, 0, 2'b00, 0, 0, 0, 2'b01, 10, 0, "R4 retire");

        // R6: retirement against an empty count
        step(0, 3'b000, 0, 0, 0, 2'b00, 0, 0, 0, 2'b01, 20, 0, "R6");
        chk(m_err == 1'b1, "R6 model expects pulse", m_err, 1);
        idle("R6 pulse ends");
        check_all("R6");

        // R10: destinations offered without valid do nothing
        step(0, 3'b000, 0, 0, 0, 2'b11, 11, 12, 6, 2'b00, 0, 0, "R10");
        check_all("R10");

        // R3 sweep over every index with varied latency, then release
        for (int i = 1; i < NREG; i++)
            step(1, 3'b000, 0, 0, 0, 2'b01, i, 0, i % 16, 2'b00, 0, 0, "R3 sweep");
        check_all("R3 sweep");
        for (int i = 1; i < NREG; i += 2)
            step(0, 3'b000, 0, 0, 0, 2'b00, 0, 0, 0, (i + 1 < NREG) ? 2'b11 : 2'b01, i, i + 1, "R4 sweep");
        check_all("R4 sweep");

        // Long irregular run over crowded registers
        for (int n = 0; n < 400; n++) begin
            int pick[7];
            for (int k = 0; k < 7; k++) pick[k] = int'($urandom % 4) + ((($urandom % 2) == 1) ? 32 : 0);
            step($urandom % 4 != 0, 3'($urandom), pick[0], pick[1], pick[2],
                 2'($urandom), pick[3], pick[4], int'($urandom % 16),
                 2'($urandom), pick[5], pick[6], "R1 random");
            if (n % 25 == 0) check_all("R2 random");
        end
        check_all("R2 final");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule